// File: doc/BRIEF.md
# NAND Large-Page Read Sequencer

This block runs whole read operations against an 8-bit NAND device with 2048-byte main pages, 64 spare bytes per page and 64 pages per block. A single start pulse selects one of three operations. A page read sends the first read command, two column bytes, two row bytes and the confirm command. It then waits for the device to report ready and streams the requested number of bytes out on a valid/ready port. A device reset sends one reset command and waits. A bad-block check reads the first spare byte of the block's first page and reports a result flag.

The block generates every bus cycle itself: command latch, address latch, write strobe and read strobe, with the strobe width set by a parameter. It watches ready/busy through a synchronizer and an edge detector. The detector sets a sticky flag, which software clears by pulsing a clear input, and it drives an interrupt output when that is enabled. The flag is cleared when each operation starts. A programmable timeout ends a wait that never sees an edge and marks the operation as failed.

Top module: `nand_page_reader`

## Requirements
- R1: A read operation drives exactly six latched bytes in this order: command 0x00, column[7:0], {4'b0, column[11:8]}, row[7:0], row[15:8], command 0x30. Here row = block*64 + page. Command bytes are latched with nand_cle=1 and address bytes with nand_ale=1, and the two are never high together.
- R2: After the confirm command, no read strobe occurs until the ready flag is set. The block then delivers op_len bytes on dout_data, taken from consecutive columns starting at op_col, one per valid&ready handshake. dout_data stays stable while dout_valid=1 and dout_ready=0. When op_len is 0, no byte is delivered.
- R3: A reset operation (op_kind=1) latches only the command 0xFF, with no address bytes. It then waits for the ready flag and completes.
- R4: A bad-block check (op_kind=2) latches 0x00, 0x00, 0x08, row[7:0], row[15:8], 0x30 with row = block*64. It reads one byte and delivers none on dout. op_bad is 1 at op_done exactly when that byte is not 0xFF.
- R5: rb_flag is set by a low-to-high transition of nand_rb when rb_fall_mode=0, and by a high-to-low transition when rb_fall_mode=1. The opposite transition is ignored. The flag stays set until a flag_clr pulse. rb_level follows the synchronized nand_rb.
- R6: irq is 1 when rb_flag=1 and irq_en=1, and 0 when irq_en=0.
- R7: If the ready flag is not set within timeout_clks clocks of the wait starting, the operation ends with op_err=1 at op_done, no data is delivered, and nand_ce_n returns to 1.
- R8: nand_ce_n is 0 during every strobe of an operation and 1 when no operation is in progress. op_done is a one-cycle pulse seen with op_busy=0. A successful operation ends with op_err=0.
- R9: After reset: nand_ce_n=1, nand_we_n=1, nand_re_n=1, nand_cle=0, nand_ale=0, nand_io_oe=0, rb_flag=0, irq=0, dout_valid=0, op_busy=0.
- R10: Starting an operation clears rb_flag, so a flag left set by an earlier event cannot end the new operation's wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Start pulse, taken when idle |
| op_kind | input | 2 | 0 read, 1 reset, 2 bad-block check |
| op_block | input | 10 | Block number |
| op_page | input | 6 | Page number in block |
| op_col | input | 12 | Start column for a read |
| op_len | input | 12 | Bytes to deliver for a read |
| timeout_clks | input | 16 | Ready-wait limit in clocks |
| rb_fall_mode | input | 1 | 1 selects high-to-low edge detection |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Pulse clears rb_flag |
| op_busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Last operation timed out |
| op_bad | output | 1 | Last bad-block check found a marked block |
| dout_valid | output | 1 | Data byte valid |
| dout_data | output | 8 | Data byte |
| dout_ready | input | 1 | Consumer accepts byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven to device |
| nand_io_oe | output | 1 | Drive enable for nand_io_out |
| nand_io_in | input | 8 | Byte from device |
| nand_rb | input | 1 | Device ready/busy, 1 = ready |
| rb_flag | output | 1 | Sticky ready transition flag |
| rb_level | output | 1 | Synchronized ready/busy level |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume op_start and flag_clr are single-cycle pulses. They also assume flag_clr never coincides with an operation start, and that the device keeps nand_rb stable while no busy period is in progress. The bench meets these conditions in three ways. It pulses controls for one cycle at the falling edge. It moves nand_rb through the device model only after a confirm or reset command, and it moves the line by hand only while the block is idle. It keeps every random column and length inside the 2112-byte page.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
    localparam int BLK_W   = 10;
    localparam int PG_W    = 6;
    localparam int ROW_W   = BLK_W + PG_W;
    localparam int COL_W   = 12;
    localparam int LEN_W   = 12;
    localparam int TO_W    = 16;
    localparam int PAGES   = 1 << PG_W;
    localparam logic [7:0] CMD_RD1 = 8'h00;
    localparam logic [7:0] CMD_RD2 = 8'h30;
    localparam logic [7:0] CMD_RST = 8'hFF;
    localparam logic [COL_W-1:0] SPARE_COL = 12'd2048;

    typedef enum logic [1:0] {OP_READ = 2'd0, OP_RESET = 2'd1, OP_BADCHK = 2'd2} op_kind_e;
    typedef enum logic [1:0] {BC_CMD, BC_ADDR, BC_READ} bus_kind_e;

    typedef struct packed {
        bus_kind_e  kind;
        logic [7:0] val;
    } bus_req_t;

    function automatic logic [ROW_W-1:0] row_of(logic [BLK_W-1:0] blk, logic [PG_W-1:0] pg);
        return ROW_W'(blk) * ROW_W'(PAGES) + ROW_W'(pg);
    endfunction

    function automatic logic [7:0] addr_byte(logic [1:0] idx, logic [COL_W-1:0] col,
                                             logic [ROW_W-1:0] row);
        case (idx)
            2'd0:    return col[7:0];
            2'd1:    return 8'(col >> 8);
            2'd2:    return row[7:0];
            default: return row[15:8];
        endcase
    endfunction
endpackage

// File: rtl/nand_bus_cycler.sv
module nand_bus_cycler
    import nand_rd_pkg::*;
#(
    parameter int PULSE = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  bus_req_t   req,
    output logic       cyc_idle,
    output logic       cyc_done,
    output logic [7:0] rd_byte,
    input  logic [7:0] io_in,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe
);
    localparam int CW = $clog2(PULSE + 1);
    typedef enum logic [1:0] {C_IDLE, C_SETUP, C_STROBE, C_HOLD} cyc_st_e;

    cyc_st_e  st;
    bus_req_t cur;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= C_IDLE;
            cur      <= '{kind: BC_CMD, val: 8'h00};
            cnt      <= '0;
            cyc_done <= 1'b0;
            rd_byte  <= 8'h00;
        end else begin
            cyc_done <= 1'b0;
            case (st)
                C_IDLE: if (req_valid) begin
                    cur <= req;
                    st  <= C_SETUP;
                end
                C_SETUP: begin
                    cnt <= '0;
                    st  <= C_STROBE;
                end
                C_STROBE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(PULSE - 1)) begin
                        if (cur.kind == BC_READ) rd_byte <= io_in;
                        st <= C_HOLD;
                    end
                end
                default: begin
                    st       <= C_IDLE;
                    cyc_done <= 1'b1;
                end
            endcase
        end
    end

    wire active = (st != C_IDLE);
    assign cyc_idle = (st == C_IDLE);
    assign cle    = active && cur.kind == BC_CMD;
    assign ale    = active && cur.kind == BC_ADDR;
    assign io_oe  = active && cur.kind != BC_READ;
    assign io_out = cur.val;
    assign we_n   = !(st == C_STROBE && cur.kind != BC_READ);
    assign re_n   = !(st == C_STROBE && cur.kind == BC_READ);
endmodule

// File: rtl/nand_rb_detect.sv
module nand_rb_detect (
    input  logic clk,
    input  logic rst,
    input  logic rb_raw,
    input  logic fall_mode,
    input  logic irq_en,
    input  logic clr,
    output logic flag,
    output logic level,
    output logic irq
);
    logic s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            prev <= 1'b1;
        end else begin
            s1   <= rb_raw;
            s2   <= s1;
            prev <= s2;
        end
    end

    wire edge_hit = fall_mode ? (prev && !s2) : (!prev && s2);

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (edge_hit) flag <= 1'b1;
        else if (clr)      flag <= 1'b0;
    end

    assign level = s2;
    assign irq   = flag && irq_en;
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
    import nand_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_start,
    input  op_kind_e         op_kind,
    input  logic [BLK_W-1:0] op_block,
    input  logic [PG_W-1:0]  op_page,
    input  logic [COL_W-1:0] op_col,
    input  logic [LEN_W-1:0] op_len,
    input  logic [TO_W-1:0]  timeout_clks,
    input  logic             rb_flag,
    input  logic             cyc_idle,
    input  logic             cyc_done,
    input  logic [7:0]       rd_byte,
    input  logic             dout_ready,
    output logic             req_valid,
    output bus_req_t         req,
    output logic             flag_clr_int,
    output logic             ce_n,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             bad,
    output logic             dout_valid,
    output logic [7:0]       dout_data
);
    typedef enum logic [2:0] {S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_WAIT, S_READ, S_OUT, S_END} seq_st_e;

    seq_st_e          st;
    op_kind_e         kind;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [LEN_W-1:0] len, sent_n;
    logic [TO_W-1:0]  wait_n;
    logic [1:0]       idx;
    logic             issued;

    always_comb begin
        req = '{kind: BC_CMD, val: CMD_RD1};
        case (st)
            S_CMD1:  req.val = (kind == OP_RESET) ? CMD_RST : CMD_RD1;
            S_ADDR:  req = '{kind: BC_ADDR, val: addr_byte(idx, col, row)};
            S_CMD2:  req.val = CMD_RD2;
            S_READ:  req.kind = BC_READ;
            default: ;
        endcase
    end

    wire issuing = (st == S_CMD1) || (st == S_ADDR) || (st == S_CMD2) || (st == S_READ);
    assign req_valid    = issuing && !issued && cyc_idle;
    assign flag_clr_int = (st == S_IDLE) && op_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; kind <= OP_READ; col <= '0; row <= '0; len <= '0;
            sent_n <= '0; wait_n <= '0; idx <= '0; issued <= 1'b0;
            ce_n <= 1'b1; busy <= 1'b0; done <= 1'b0; err <= 1'b0; bad <= 1'b0;
            dout_valid <= 1'b0; dout_data <= 8'h00;
        end else begin
            done <= 1'b0;
            if (req_valid) issued <= 1'b1;
            if (cyc_done)  issued <= 1'b0;
            case (st)
                S_IDLE: if (op_start) begin
                    kind   <= op_kind;
                    col    <= (op_kind == OP_BADCHK) ? SPARE_COL : op_col;
                    row    <= row_of(op_block, (op_kind == OP_BADCHK) ? '0 : op_page);
                    len    <= (op_kind == OP_BADCHK) ? LEN_W'(1) : op_len;
                    sent_n <= '0;
                    idx    <= '0;
                    ce_n   <= 1'b0;
                    busy   <= 1'b1;
                    err    <= 1'b0;
                    bad    <= 1'b0;
                    st     <= S_CMD1;
                end
                S_CMD1: if (cyc_done) begin
                    wait_n <= '0;
                    st     <= (kind == OP_RESET) ? S_WAIT : S_ADDR;
                end
                S_ADDR: if (cyc_done) begin
                    idx <= idx + 1'b1;
                    if (idx == 2'd3) st <= S_CMD2;
                end
                S_CMD2: if (cyc_done) begin
                    wait_n <= '0;
                    st     <= S_WAIT;
                end
                S_WAIT: begin
                    if (rb_flag) begin
                        st <= (kind == OP_RESET || len == '0) ? S_END : S_READ;
                    end else if (wait_n == timeout_clks) begin
                        err <= 1'b1;
                        st  <= S_END;
                    end else begin
                        wait_n <= wait_n + 1'b1;
                    end
                end
                S_READ: if (cyc_done) begin
                    if (kind == OP_BADCHK) begin
                        bad <= (rd_byte != 8'hFF);
                        st  <= S_END;
                    end else begin
                        dout_data  <= rd_byte;
                        dout_valid <= 1'b1;
                        st         <= S_OUT;
                    end
                end
                S_OUT: if (dout_ready) begin
                    dout_valid <= 1'b0;
                    sent_n     <= sent_n + 1'b1;
                    st         <= (sent_n + 1'b1 == len) ? S_END : S_READ;
                end
                default: begin
                    ce_n <= 1'b1;
                    busy <= 1'b0;
                    done <= 1'b1;
                    st   <= S_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
    import nand_rd_pkg::*;
#(
    parameter int PULSE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_start,
    input  logic [1:0]       op_kind,
    input  logic [BLK_W-1:0] op_block,
    input  logic [PG_W-1:0]  op_page,
    input  logic [COL_W-1:0] op_col,
    input  logic [LEN_W-1:0] op_len,
    input  logic [TO_W-1:0]  timeout_clks,
    input  logic             rb_fall_mode,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             op_busy,
    output logic             op_done,
    output logic             op_err,
    output logic             op_bad,
    output logic             dout_valid,
    output logic [7:0]       dout_data,
    input  logic             dout_ready,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb,
    output logic             rb_flag,
    output logic             rb_level,
    output logic             irq
);
    bus_req_t   req;
    logic       req_valid, cyc_idle, cyc_done, clr_int;
    logic [7:0] rd_byte;

    nand_rd_seq seq_i (
        .clk, .rst, .op_start, .op_kind(op_kind_e'(op_kind)), .op_block, .op_page,
        .op_col, .op_len, .timeout_clks, .rb_flag, .cyc_idle, .cyc_done, .rd_byte,
        .dout_ready, .req_valid, .req, .flag_clr_int(clr_int), .ce_n(nand_ce_n),
        .busy(op_busy), .done(op_done), .err(op_err), .bad(op_bad), .dout_valid, .dout_data
    );

    nand_bus_cycler #(.PULSE(PULSE)) cyc_i (
        .clk, .rst, .req_valid, .req, .cyc_idle, .cyc_done, .rd_byte, .io_in(nand_io_in),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .io_out(nand_io_out), .io_oe(nand_io_oe)
    );

    nand_rb_detect rb_i (
        .clk, .rst, .rb_raw(nand_rb), .fall_mode(rb_fall_mode), .irq_en,
        .clr(flag_clr || clr_int), .flag(rb_flag), .level(rb_level), .irq
    );
endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_start,
    input logic       flag_clr,
    input logic       op_busy,
    input logic       op_done,
    input logic       dout_valid,
    input logic       dout_ready,
    input logic [7:0] dout_data,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       rb_flag
);
    a_r1_latch_excl: assert property (@(posedge clk) disable iff (rst) !(nand_cle && nand_ale));
    a_r2_hold_data: assert property (@(posedge clk) disable iff (rst)
        dout_valid && !dout_ready |=> dout_valid && $stable(dout_data));
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        rb_flag && !flag_clr && !op_start |=> rb_flag);
    a_r8_ce_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst) op_done |-> !op_busy);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst) op_done |=> !op_done);
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst) !(!nand_we_n && !nand_re_n));
endmodule

bind nand_page_reader nand_page_reader_chk chk_i (.*);

// File: tb/nand_page_reader_tb_top.sv
`timescale 1ns/1ps
module nand_page_reader_tb_top;
    logic clk = 0, rst = 1;
    always #2.5 clk = ~clk;

    logic op_start = 0, rb_fall_mode = 0, irq_en = 0, flag_clr = 0, dout_ready = 0;
    logic [1:0] op_kind = 0;
    logic [9:0] op_block = 0;
    logic [5:0] op_page = 0;
    logic [11:0] op_col = 0, op_len = 0;
    logic [15:0] timeout_clks = 16'd300;
    logic op_busy, op_done, op_err, op_bad, dout_valid;
    logic [7:0] dout_data, nand_io_out, nand_io_in;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, nand_rb;
    logic rb_flag, rb_level, irq;

    nand_page_reader dut_i (.*);

    int checks = 0, failures = 0;
    localparam int BUSY_T = 20;

    // device model state
    logic dev_rb = 1, dev_dead = 0, rb_ovr_en = 0, rb_ovr = 1;
    logic prev_we = 1, prev_re = 1;
    logic [7:0] ab[4];
    int acnt = 0, pre_cnt = 0, busy_cnt = 0;
    int dev_row = 0, dev_col = 0;
    logic [7:0] lg[16];
    int lg_n = 0, ce_bad = 0;
    logic [7:0] rx[80];
    int rx_n = 0;

    function automatic logic [7:0] dev_byte(int row, int col);
        if (col == 2048 && (row % 64) == 0)
            return ((row / 64) % 7 == 3) ? 8'h00 : 8'hFF;
        return 8'((row * 37) ^ (col * 11) ^ (col >> 3));
    endfunction

    assign nand_io_in = !nand_re_n ? dev_byte(dev_row, dev_col) : 8'h00;
    assign nand_rb = rb_ovr_en ? rb_ovr : dev_rb;

    always @(negedge clk) begin
        if (!prev_we && nand_we_n) begin
            if (lg_n < 16) lg[lg_n] = nand_io_out;
            lg_n++;
            if (nand_ce_n) ce_bad++;
            if (nand_cle) begin
                if (nand_io_out == 8'h00) acnt = 0;
                if (nand_io_out == 8'h30) begin
                    dev_col = {ab[1][3:0], ab[0]};
                    dev_row = {ab[3], ab[2]};
                end
                if ((nand_io_out == 8'h30 || nand_io_out == 8'hFF) && !dev_dead) pre_cnt = 3;
            end
            if (nand_ale && acnt < 4) begin ab[acnt] = nand_io_out; acnt++; end
        end
        if (!prev_re && nand_re_n) begin
            dev_col++;
            if (nand_ce_n) ce_bad++;
        end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
        if (pre_cnt > 0) begin
            pre_cnt--;
            if (pre_cnt == 0) begin dev_rb = 0; busy_cnt = BUSY_T; end
        end else if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) dev_rb = 1;
        end
        // consumer: choose ready, then record the byte that moves at the next edge
        if (!rst) begin
            dout_ready = ($urandom % 4) != 0;
            if (dout_valid && dout_ready) begin
                if (rx_n < 80) rx[rx_n] = dout_data;
                rx_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic r_err, r_bad;

    task automatic run_op(input int kind, input int blk, input int pg, input int col, input int len);
        lg_n = 0; rx_n = 0; ce_bad = 0;
        @(negedge clk);
        op_kind = 2'(kind); op_block = 10'(blk); op_page = 6'(pg);
        op_col = 12'(col); op_len = 12'(len); op_start = 1;
        @(negedge clk);
        op_start = 0;
        while (!op_done) @(negedge clk);
        r_err = op_err; r_bad = op_bad;
        chk(!op_busy, "R8 busy low at done", op_busy, 0);
        @(negedge clk);
        chk(nand_ce_n == 1 && ce_bad == 0, "R8 chip enable", ce_bad, 0);
        while (busy_cnt > 0 || pre_cnt > 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_addr_log(input string tag, input int col, input int row);
        bit ok;
        ok = (lg_n == 6) && lg[0] == 8'h00 && lg[1] == 8'(col) && lg[2] == 8'(col >> 8)
             && lg[3] == 8'(row) && lg[4] == 8'(row >> 8) && lg[5] == 8'h30;
        chk(ok, tag, lg_n, 6);
    endtask

    task automatic do_read(input int blk, input int pg, input int col, input int len);
        int row;
        int bad_n;
        row = blk * 64 + pg;
        run_op(0, blk, pg, col, len);
        check_addr_log("R1 read cmd/addr order", col, row);
        chk(r_err == 0, "R8 no error on read", r_err, 0);
        chk(rx_n == len, "R2 byte count", rx_n, len);
        bad_n = 0;
        for (int i = 0; i < len && i < rx_n; i++)
            if (rx[i] !== dev_byte(row, col + i)) begin
                if (bad_n == 0) chk(0, "R2 data byte", rx[i], dev_byte(row, col + i));
                bad_n++;
            end
        if (bad_n == 0) chk(1, "R2 data bytes", 0, 0);
    endtask

    task automatic idle_wait(); repeat (6) @(negedge clk); endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe,
            "R9 bus idle at reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}, 6'b111000);
        chk(!rb_flag && !irq && !dout_valid && !op_busy, "R9 status at reset",
            {rb_flag, irq, dout_valid, op_busy}, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        chk(nand_ce_n && !op_busy && !rb_flag, "R9 idle after reset", {nand_ce_n, op_busy, rb_flag}, 3'b100);

        // directed reads
        do_read(0, 0, 0, 64);
        do_read(1023, 63, 2047, 3);
        do_read(77, 5, 2111, 1);
        do_read(12, 34, 100, 0);
        // random reads
        for (int n = 0; n < 14; n++) begin
            int col, mx;
            col = $urandom % 2112;
            mx = 2112 - col;
            if (mx > 40) mx = 40;
            do_read($urandom % 1024, $urandom % 64, col, 1 + ($urandom % mx));
        end

        // R3 reset operation
        run_op(1, 0, 0, 0, 0);
        chk(lg_n == 1 && lg[0] == 8'hFF, "R3 only reset command", lg_n, 1);
        chk(r_err == 0 && rx_n == 0, "R3 completes cleanly", {r_err, 8'(rx_n)}, 0);

        // R4 bad block checks
        run_op(2, 3, 17, 5, 9);
        check_addr_log("R4 badchk address", 2048, 3 * 64);
        chk(r_bad == 1 && rx_n == 0, "R4 marked block", {r_bad, 8'(rx_n)}, 9'h100);
        run_op(2, 4, 0, 0, 0);
        chk(r_bad == 0 && r_err == 0, "R4 good block", {r_bad, r_err}, 0);

        // R6 interrupt with flag left set by last op
        chk(rb_flag == 1, "R5 flag sticky after op", rb_flag, 1);
        irq_en = 1; @(negedge clk);
        chk(irq == 1, "R6 irq enabled", irq, 1);
        irq_en = 0; @(negedge clk);
        chk(irq == 0, "R6 irq masked", irq, 0);
        flag_clr = 1; @(negedge clk); flag_clr = 0; @(negedge clk);
        chk(rb_flag == 0, "R5 write-one clear", rb_flag, 0);

        // R5 rising mode ignores falling edge
        rb_ovr = 1; rb_ovr_en = 1; idle_wait();
        rb_ovr = 0; idle_wait();
        chk(rb_flag == 0 && rb_level == 0, "R5 fall ignored in rise mode", {rb_flag, rb_level}, 0);
        rb_ovr = 1; idle_wait();
        chk(rb_flag == 1 && rb_level == 1, "R5 rise sets flag", {rb_flag, rb_level}, 3);
        // R5 falling mode
        rb_fall_mode = 1;
        flag_clr = 1; @(negedge clk); flag_clr = 0; idle_wait();
        rb_ovr = 0; idle_wait();
        chk(rb_flag == 1, "R5 fall mode sets flag", rb_flag, 1);
        flag_clr = 1; @(negedge clk); flag_clr = 0; idle_wait();
        rb_ovr = 1; idle_wait();
        chk(rb_flag == 0, "R5 rise ignored in fall mode", rb_flag, 0);
        rb_fall_mode = 0; rb_ovr_en = 0; idle_wait();

        // R10 stale flag cleared at op start; R7 timeout with silent device
        rb_ovr = 0; rb_ovr_en = 1; idle_wait(); rb_ovr = 1; idle_wait(); rb_ovr_en = 0;
        chk(rb_flag == 1, "R10 stale flag set before op", rb_flag, 1);
        dev_dead = 1; timeout_clks = 16'd60;
        run_op(0, 9, 9, 10, 5);
        chk(r_err == 1, "R7 timeout error", r_err, 1);
        chk(rx_n == 0, "R10 stale flag did not release wait", rx_n, 0);
        dev_dead = 0; timeout_clks = 16'd300;
        do_read(200, 1, 500, 8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule